// File: doc/BRIEF.md
# Lockable PWM Channel Control Register

This block is a byte-wide control register for a six-channel PWM output stage. Its write protection is a two-stage chain. A sticky global lock, armed by a protect input, freezes a hardware-enable bit. That enable bit then decides whether a group of secondary mode fields can change. The group is a two-bit mode field and three pair-swap bits. The register also holds one mask bit per channel. A masked channel has its output held low, which gives 0% duty. An unmasked channel passes its generated waveform through unchanged. The mask bits stay writable in every lock state.

Software reaches the block through a one-bit address. At address 0 the main byte sits as follows: bit 7 is the enable, bit 6 is a constant 1, and bits 5:0 are the masks, with bit n belonging to channel n. At address 1 the mode byte sits as follows: bits 1:0 are the mode, bits 4:2 are the swap bits, and bits 7:5 read 0. The mode and swap values go out on dedicated ports to the PWM generator. Reads are combinational and always show the current contents.

Top module: `pwm_chan_ctl`

## Requirements
- R1: After a synchronous reset, address 0 reads 0x40, address 1 reads 0x00, and every channel output equals its input.
- R2: While the lock is clear, a write to address 0 loads bit 7 into the enable bit.
- R3: The lock arms in any cycle where `wp_set` is high, and that cycle's own write is already covered. Once armed it stays set until reset, and writes cannot change the enable bit.
- R4: A write to address 1 while the enable is 1 loads the mode field from bits 1:0 and the swap bits from bits 4:2. The values are visible on `mode_o` and `swap_o` after the clock edge.
- R5: A write to address 1 while the enable is 0 is discarded, and the mode and swap values stay unchanged.
- R6: A write to address 0 loads the six mask bits from bits 5:0, whatever the lock or enable state.
- R7: `pwm_out[n]` is 0 while mask bit n is 1 and equals `pwm_in[n]` while it is 0. The gating is combinational, so it follows the register in the cycle after the write.
- R8: Bit 6 of address 0 ignores writes and always reads 1. Bits 7:5 of address 1 always read 0.
- R9: Arming the lock while the enable is 1 leaves the mode and swap bits writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | Byte select: 0 = main byte, 1 = mode byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| wp_set | input | 1 | Arms the sticky global lock |
| mode_o | output | 2 | Current mode field |
| swap_o | output | 3 | Current pair-swap bits |
| pwm_in | input | 6 | Generated channel waveforms |
| pwm_out | output | 6 | Channel outputs after masking |

## Verification
The hardest state to reach is a locked register whose enable bit is 1. In that state the mode fields must stay writable while the enable itself is frozen. The stimulus reaches it in three steps. It sets the enable first. It then arms `wp_set` in the same cycle as a write that tries to clear the enable, and it writes new mode values afterwards. A second pass locks with the enable at 0. It then shows that the mode byte is dead for good while the masks still respond, until a reset releases the lock.

// File: rtl/pwmctl_pkg.sv
package pwmctl_pkg;
    localparam int NCH     = 6;
    localparam int MODE_W  = 2;
    localparam int NSWP    = 3;
    localparam int DW      = 8;
    localparam int EN_BIT  = 7;
    localparam int RSV_BIT = 6;
    localparam int AUX_W   = MODE_W + NSWP;
    localparam int PAD_W   = DW - AUX_W;

    typedef struct packed {
        logic              en;
        logic [NSWP-1:0]   swp;
        logic [MODE_W-1:0] mode;
        logic [NCH-1:0]    mask;
    } ctl_t;

    typedef enum logic {SEL_MAIN = 1'b0, SEL_AUX = 1'b1} sel_e;

    function automatic logic [DW-1:0] pack_main(input ctl_t c);
        return {c.en, 1'b1, c.mask};
    endfunction

    function automatic logic [DW-1:0] pack_aux(input ctl_t c);
        return {{PAD_W{1'b0}}, c.swp, c.mode};
    endfunction
endpackage

// File: rtl/wp_latch.sv
module wp_latch (
    input  logic clk,
    input  logic rst,
    input  logic wp_set,
    output logic lock_eff
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst)         locked_q <= 1'b0;
        else if (wp_set) locked_q <= 1'b1;
    end

    assign lock_eff = locked_q | wp_set;

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        lock_eff |=> lock_eff);
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
    import pwmctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    input  logic          lock,
    output ctl_t          ctl
);
    ctl_t ctl_q;
    logic unused_wbits;

    assign unused_wbits = wdata[RSV_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_MAIN) begin
                ctl_q.mask <= wdata[NCH-1:0];
                if (!lock) ctl_q.en <= wdata[EN_BIT];
            end else if (ctl_q.en) begin
                ctl_q.mode <= wdata[MODE_W-1:0];
                ctl_q.swp  <= wdata[AUX_W-1:MODE_W];
            end
        end
    end

    assign ctl = ctl_q;

    p_en_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(ctl_q.en));
    p_aux_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.en |=> ($stable(ctl_q.mode) && $stable(ctl_q.swp)));
    p_aux_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_AUX && ctl_q.en) |=>
            (ctl_q.mode == $past(wdata[MODE_W-1:0])));
    p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_MAIN) |=> (ctl_q.mask == $past(wdata[NCH-1:0])));
    p_en_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_MAIN && !lock) |=> (ctl_q.en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/chan_mask.sv
module chan_mask
    import pwmctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] pwm_in,
    output logic [NCH-1:0] pwm_out
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign pwm_out[i] = mask[i] ? 1'b0 : pwm_in[i];

        p_mask_zero_r7: assert property (@(posedge clk) disable iff (rst)
            mask[i] |-> !pwm_out[i]);
        p_mask_pass_r7: assert property (@(posedge clk) disable iff (rst)
            !mask[i] |-> (pwm_out[i] == pwm_in[i]));
    end
endmodule

// File: rtl/pwm_chan_ctl.sv
module pwm_chan_ctl
    import pwmctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              wp_set,
    output logic [MODE_W-1:0] mode_o,
    output logic [NSWP-1:0]   swap_o,
    input  logic [NCH-1:0]    pwm_in,
    output logic [NCH-1:0]    pwm_out
);
    logic lock;
    ctl_t ctl;
    sel_e sel;

    assign sel = sel_e'(addr);

    wp_latch u_lock (
        .clk      (clk),
        .rst      (rst),
        .wp_set   (wp_set),
        .lock_eff (lock)
    );

    ctl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wdata),
        .lock  (lock),
        .ctl   (ctl)
    );

    chan_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .mask    (ctl.mask),
        .pwm_in  (pwm_in),
        .pwm_out (pwm_out)
    );

    always_comb begin
        rdata = (sel == SEL_MAIN) ? pack_main(ctl) : pack_aux(ctl);
    end

    assign mode_o = ctl.mode;
    assign swap_o = ctl.swp;

    p_rsvd_one_r8: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_MAIN) |-> rdata[RSV_BIT]);
    p_aux_pad_r8: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_AUX) |-> (rdata[DW-1:AUX_W] == '0));
endmodule

// File: tb/sim_pwm_chan_ctl.sv
`timescale 1ns/1ps
module sim_pwm_chan_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       wp_set = 1'b0;
    logic [1:0] mode_o;
    logic [2:0] swap_o;
    logic [5:0] pwm_in = '0;
    logic [5:0] pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_chan_ctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wp_set(wp_set), .mode_o(mode_o), .swap_o(swap_o),
        .pwm_in(pwm_in), .pwm_out(pwm_out)
    );

    // Vector: {addr, wdata, wp, pwm_in, exp_main, exp_aux, exp_out} = 38 bits
    localparam int NV = 9;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 8'h3F, 1'b0, 6'h3F, 8'h7F, 8'h00, 6'h00}, // R6 R7 en stays 0
        {1'b1, 8'h1F, 1'b0, 6'h3F, 8'h7F, 8'h00, 6'h00}, // R5 discarded
        {1'b0, 8'h80, 1'b0, 6'h2A, 8'hC0, 8'h00, 6'h2A}, // R2 en set, R7 pass
        {1'b1, 8'h1F, 1'b0, 6'h15, 8'hC0, 8'h1F, 6'h15}, // R4 load
        {1'b0, 8'h95, 1'b0, 6'h3F, 8'hD5, 8'h1F, 6'h2A}, // R6 R7
        {1'b1, 8'hE9, 1'b0, 6'h3F, 8'hD5, 8'h09, 6'h2A}, // R4 R8 pad
        {1'b0, 8'h05, 1'b1, 6'h3F, 8'hC5, 8'h09, 6'h3A}, // R3 same-cycle lock
        {1'b0, 8'h00, 1'b0, 6'h3F, 8'hC0, 8'h09, 6'h3F}, // R3 R6 locked
        {1'b1, 8'h12, 1'b0, 6'h3F, 8'hC0, 8'h12, 6'h3F}  // R9 locked, en=1
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d, input logic wp, input logic [5:0] pin);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wp_set = wp; pwm_in = pin;
        @(negedge clk);
        wr_en = 1'b0; wp_set = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] em, input logic [7:0] ea);
        addr = 1'b0; #1; chk(req, rdata, em);
        addr = 1'b1; #1; chk(req, rdata, ea);
        chk(req, {6'b0, mode_o}, {6'b0, ea[1:0]});
        chk(req, {5'b0, swap_o}, {5'b0, ea[4:2]});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        do_reset();
        pwm_in = 6'h2D; #1;
        rd_chk("R1", 8'h40, 8'h00);
        chk("R1", {2'b0, pwm_out}, 8'h2D);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][37], VEC[i][36:29], VEC[i][28], VEC[i][27:22]);
            chk("R7", {2'b0, pwm_out}, {2'b0, VEC[i][5:0]});
            rd_chk("R4/R5/R6 vec", VEC[i][21:14], VEC[i][13:6]);
        end

        // Lock with enable at 0: enable frozen (R3), mode dead (R5), masks live (R6)
        do_reset();
        rd_chk("R1 after reset", 8'h40, 8'h00);
        wr(1'b0, 8'h00, 1'b1, 6'h3F);
        wr(1'b0, 8'hFF, 1'b0, 6'h3F);
        rd_chk("R3 enable frozen at 0", 8'h7F, 8'h00);
        chk("R7 all masked", {2'b0, pwm_out}, 8'h00);
        wr(1'b1, 8'h1B, 1'b0, 6'h3F);
        rd_chk("R5 locked with en=0", 8'h7F, 8'h00);
        wr(1'b0, 8'h8C, 1'b0, 6'h3F);
        rd_chk("R6 mask while locked", 8'h4C, 8'h00);
        chk("R7 partial mask", {2'b0, pwm_out}, 8'h33);
        // R8: write bit 6 as 0, still reads 1
        wr(1'b0, 8'h01, 1'b0, 6'h3F);
        rd_chk("R8 reserved bit", 8'h41, 8'h00);

        // Reset releases the lock (R3), enable writable again (R2)
        do_reset();
        wr(1'b0, 8'h80, 1'b0, 6'h00);
        rd_chk("R2 after unlock", 8'hC0, 8'h00);
        wr(1'b0, 8'h00, 1'b0, 6'h00);
        rd_chk("R2 clear enable", 8'h40, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule